// File: doc/BRIEF.md
# Serial Controller Host Register File

This block is the byte-wide host side of a classic serial port controller. A host addresses eight byte offsets with a 3-bit address and separate read and write strobes. The block stores the character format, the modem control bits, the interrupt enables, a scratch byte and a 16-bit baud divisor. It drives these settings to the transmitter, the receiver, the baud generator and the modem pins. It also returns status that neighbouring blocks supply.

Several offsets are overloaded. Bit 7 of the format register is a divisor access switch: while it is set, offsets 0 and 1 reach the divisor bytes instead of the data path and the interrupt enables. Offset 2 reads the interrupt identification but writes the FIFO control. Accesses with side effects produce one-cycle strobes, registered one cycle after the access: transmit load, receive pop, identification read, modem status read, and the FIFO resets. The serial shifters, the FIFOs and interrupt prioritisation are built elsewhere and only use these strobes and bits.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the format, modem control, interrupt enable, scratch, FIFO control and divisor state are all zero and `baud_run` is 0. Line status reads 0x20, with only the transmit-empty bit 5 set while `rx_ready` is 0.
- R2: While format bit 7 is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. In that mode a write to offset 0 gives no `tx_load`, and a read of offset 0 gives no `rx_pop`. The data path and the interrupt enables are left untouched.
- R3: A write to offset 0 with format bit 7 clear pulses `tx_load` for one cycle, in the cycle after the write. `tx_data` holds the written byte.
- R4: A read of offset 0 with format bit 7 clear returns `rx_data` in the same cycle. It pulses `rx_pop` for one cycle in the cycle after the read.
- R5: Offset 3 stores the format byte and reads it back. The byte decodes as follows: [1:0] `word_len`, bit2 `two_stop`, bit3 `parity_en`, bit4 `parity_even`, bit5 `parity_stick`, bit6 `break_ctl`.
- R6: Offset 4 stores five modem control bits and reads back {3'b000, bits[4:0]}. The bits map as follows: bit0 `dtr`, bit1 `rts`, bit2 `out1`, bit3 `irq_out_en`, bit4 `loopback`.
- R7: A write to offset 2 stores bit0 as `fifo_en` and bits[7:6] as `rx_trigger`. Bit1 gives a one-cycle `rx_fifo_rst` and bit2 a one-cycle `tx_fifo_rst`, both in the next cycle; neither bit is stored. A read of offset 2 returns {fifo_en, fifo_en, 2'b00, int_code} and pulses `int_id_rd` in the next cycle.
- R8: Line status bits 1 (overrun), 2 (parity) and 3 (framing) are set by the `ovr_evt`, `par_evt` and `frm_evt` pulses and stay set until offset 5 is read. The read returns the value held before it and then clears them. An event in the same cycle as the read survives the clear. Bit 0 mirrors `rx_ready`.
- R9: Line status bit 5 clears on a transmit load and sets on a `tx_taken` pulse. When both occur in one cycle, it clears.
- R10: `divisor` presents {high, low}. `baud_run` is 1 exactly when the divisor is non-zero.
- R11: Offset 1 with format bit 7 clear stores the low four bits as `irq_enable` and reads back {4'b0000, irq_enable}. Offset 7 stores and returns a full byte with no side effect.
- R12: A read of offset 6 returns `modem_in` and pulses `msr_rd` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe, one access per cycle high |
| rd_en | input | 1 | Read strobe, one access per cycle high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| tx_load | output | 1 | Transmit byte load pulse |
| tx_data | output | 8 | Last byte written for transmit |
| tx_taken | input | 1 | Transmitter took the held byte |
| rx_data | input | 8 | Received byte at the head of the receive path |
| rx_ready | input | 1 | Receive data available |
| rx_pop | output | 1 | Received byte consumed pulse |
| ovr_evt | input | 1 | Receiver overrun event |
| par_evt | input | 1 | Receiver parity error event |
| frm_evt | input | 1 | Receiver framing error event |
| int_code | input | 4 | Interrupt identification code from the prioritiser |
| int_id_rd | output | 1 | Identification read pulse |
| modem_in | input | 8 | Modem status byte |
| msr_rd | output | 1 | Modem status read pulse |
| irq_enable | output | 4 | Interrupt source enables |
| word_len | output | 2 | Character length code |
| two_stop | output | 1 | Two stop bits |
| parity_en | output | 1 | Parity generation and check |
| parity_even | output | 1 | Even parity |
| parity_stick | output | 1 | Forced parity |
| break_ctl | output | 1 | Drive a break |
| dtr | output | 1 | Terminal ready line |
| rts | output | 1 | Request to send line |
| out1 | output | 1 | Auxiliary output |
| irq_out_en | output | 1 | Interrupt output enable |
| loopback | output | 1 | Loopback mode |
| divisor | output | 16 | Baud divisor, clock at 16x bit rate |
| baud_run | output | 1 | Baud generator enable |
| fifo_en | output | 1 | FIFOs enabled |
| rx_trigger | output | 2 | Receive trigger level code |
| rx_fifo_rst | output | 1 | Receive FIFO reset pulse |
| tx_fifo_rst | output | 1 | Transmit FIFO reset pulse |

## Verification
A wrong divisor access bit shows up at once in two ways. Offset 0 writes then produce or lose `tx_load` in the next cycle, and the `divisor` or `irq_enable` outputs move when they should not. A stuck or lost sticky error bit shows on the next line status read. The read-then-clear ordering needs two reads in a row, with an event placed in the cycle of the first read. Register storage faults appear on the decoded control pins one cycle after the write, and on readback in the same cycle as the read.

// File: rtl/uart_reg_pkg.sv
package uart_reg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int NREG   = 1 << ADDR_W;
  localparam int IEN_W  = 4;
  localparam int MCTL_W = 5;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 2 * DATA_W;
  localparam int NPULSE = 6;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDFC  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_FMT   = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MCTL  = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

  localparam int FMT_DIVSEL = 7;

  // pulse vector slots
  localparam int P_TXLD  = 0;
  localparam int P_RXPOP = 1;
  localparam int P_IDRD  = 2;
  localparam int P_MSRD  = 3;
  localparam int P_RXRST = 4;
  localparam int P_TXRST = 5;

  typedef struct packed {
    logic divsel;
    logic brk;
    logic stick;
    logic even;
    logic par;
    logic stop2;
    logic [1:0] wlen;
  } fmt_t;

  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic [DATA_W-1:0] lstat_pack(logic rdy, logic ovr, logic par,
                                                   logic frm, logic thr);
    return {2'b00, thr, 1'b0, frm, par, ovr, rdy};
  endfunction

  function automatic logic [DATA_W-1:0] idfc_pack(logic fen, logic [CODE_W-1:0] code);
    return {fen, fen, 2'b00, code};
  endfunction

  function automatic logic div_nonzero(logic [DIV_W-1:0] d);
    return |d;
  endfunction
endpackage

// File: rtl/uart_reg_decode.sv
module uart_reg_decode
  import uart_reg_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              divsel,
  output logic [NREG-1:0]   wr_hit,
  output logic [NREG-1:0]   rd_hit,
  output logic              wr_div_lo,
  output logic              wr_div_hi,
  output logic              rd_div_lo,
  output logic              rd_div_hi
);
  for (genvar i = 0; i < NREG; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i);
    if (i < 2) begin : g_shared
      assign wr_hit[i] = wr_en && (addr == OFS) && !divsel;
      assign rd_hit[i] = rd_en && (addr == OFS) && !divsel;
    end else begin : g_plain
      assign wr_hit[i] = wr_en && (addr == OFS);
      assign rd_hit[i] = rd_en && (addr == OFS);
    end
  end

  assign wr_div_lo = wr_en && (addr == OFS_DATA) && divsel;
  assign wr_div_hi = wr_en && (addr == OFS_IEN)  && divsel;
  assign rd_div_lo = rd_en && (addr == OFS_DATA) && divsel;
  assign rd_div_hi = rd_en && (addr == OFS_IEN)  && divsel;
endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_ready,
  input  logic              ovr_evt,
  input  logic              par_evt,
  input  logic              frm_evt,
  input  logic              stat_rd,
  input  logic              thr_load,
  input  logic              thr_taken,
  output logic [DATA_W-1:0] line_stat
);
  logic ovr_q, par_q, frm_q, thr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
      frm_q <= 1'b0;
      thr_q <= 1'b1;
    end else begin
      ovr_q <= sticky_next(ovr_q, ovr_evt, stat_rd);
      par_q <= sticky_next(par_q, par_evt, stat_rd);
      frm_q <= sticky_next(frm_q, frm_evt, stat_rd);
      if (thr_load)       thr_q <= 1'b0;
      else if (thr_taken) thr_q <= 1'b1;
    end
  end

  assign line_stat = lstat_pack(rx_ready, ovr_q, par_q, frm_q, thr_q);
endmodule

// File: rtl/uart_pulse_reg.sv
module uart_pulse_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_reg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              tx_load,
  output logic [7:0]        tx_data,
  input  logic              tx_taken,
  input  logic [7:0]        rx_data,
  input  logic              rx_ready,
  output logic              rx_pop,
  input  logic              ovr_evt,
  input  logic              par_evt,
  input  logic              frm_evt,
  input  logic [3:0]        int_code,
  output logic              int_id_rd,
  input  logic [7:0]        modem_in,
  output logic              msr_rd,
  output logic [3:0]        irq_enable,
  output logic [1:0]        word_len,
  output logic              two_stop,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              break_ctl,
  output logic              dtr,
  output logic              rts,
  output logic              out1,
  output logic              irq_out_en,
  output logic              loopback,
  output logic [15:0]       divisor,
  output logic              baud_run,
  output logic              fifo_en,
  output logic [1:0]        rx_trigger,
  output logic              rx_fifo_rst,
  output logic              tx_fifo_rst
);
  fmt_t              fmt_q;
  logic [MCTL_W-1:0] mctl_q;
  logic [IEN_W-1:0]  ien_q;
  logic [DATA_W-1:0] scr_q, div_lo_q, div_hi_q, txd_q;
  logic              fen_q;
  logic [1:0]        trig_q;

  logic [NREG-1:0]   wr_hit, rd_hit;
  logic              wr_div_lo, wr_div_hi, rd_div_lo, rd_div_hi;
  logic [DATA_W-1:0] line_stat;
  logic [NPULSE-1:0] pulse_d, pulse_q;

  uart_reg_decode u_dec (
    .addr      (addr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .divsel    (fmt_q.divsel),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit),
    .wr_div_lo (wr_div_lo),
    .wr_div_hi (wr_div_hi),
    .rd_div_lo (rd_div_lo),
    .rd_div_hi (rd_div_hi)
  );

  // Storage registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q    <= '0;
      mctl_q   <= '0;
      ien_q    <= '0;
      scr_q    <= '0;
      div_lo_q <= '0;
      div_hi_q <= '0;
      txd_q    <= '0;
      fen_q    <= 1'b0;
      trig_q   <= '0;
    end else begin
      if (wr_hit[OFS_DATA])  txd_q    <= wdata;
      if (wr_hit[OFS_IEN])   ien_q    <= wdata[IEN_W-1:0];
      if (wr_hit[OFS_FMT])   fmt_q    <= fmt_t'(wdata);
      if (wr_hit[OFS_MCTL])  mctl_q   <= wdata[MCTL_W-1:0];
      if (wr_hit[OFS_SCR])   scr_q    <= wdata;
      if (wr_div_lo)         div_lo_q <= wdata;
      if (wr_div_hi)         div_hi_q <= wdata;
      if (wr_hit[OFS_IDFC]) begin
        fen_q  <= wdata[0];
        trig_q <= wdata[7:6];
      end
    end
  end

  uart_line_status u_lstat (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_ready  (rx_ready),
    .ovr_evt   (ovr_evt),
    .par_evt   (par_evt),
    .frm_evt   (frm_evt),
    .stat_rd   (rd_hit[OFS_LSTAT]),
    .thr_load  (wr_hit[OFS_DATA]),
    .thr_taken (tx_taken),
    .line_stat (line_stat)
  );

  // Side-effect strobes, registered one cycle after the access
  always_comb begin
    pulse_d          = '0;
    pulse_d[P_TXLD]  = wr_hit[OFS_DATA];
    pulse_d[P_RXPOP] = rd_hit[OFS_DATA];
    pulse_d[P_IDRD]  = rd_hit[OFS_IDFC];
    pulse_d[P_MSRD]  = rd_hit[OFS_MSTAT];
    pulse_d[P_RXRST] = wr_hit[OFS_IDFC] & wdata[1];
    pulse_d[P_TXRST] = wr_hit[OFS_IDFC] & wdata[2];
  end

  uart_pulse_reg #(.W(NPULSE)) u_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pulse_d),
    .q     (pulse_q)
  );

  // Read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_DATA:  rdata = rd_div_lo ? div_lo_q : rx_data;
        OFS_IEN:   rdata = rd_div_hi ? div_hi_q : {{(DATA_W-IEN_W){1'b0}}, ien_q};
        OFS_IDFC:  rdata = idfc_pack(fen_q, int_code);
        OFS_FMT:   rdata = fmt_q;
        OFS_MCTL:  rdata = {{(DATA_W-MCTL_W){1'b0}}, mctl_q};
        OFS_LSTAT: rdata = line_stat;
        OFS_MSTAT: rdata = modem_in;
        OFS_SCR:   rdata = scr_q;
        default:   rdata = '0;
      endcase
    end
  end

  logic unused_hits;
  assign unused_hits = ^{wr_hit[OFS_LSTAT], wr_hit[OFS_MSTAT], rd_hit[OFS_IEN],
                         rd_hit[OFS_FMT], rd_hit[OFS_MCTL], rd_hit[OFS_SCR]};

  assign tx_load      = pulse_q[P_TXLD];
  assign rx_pop       = pulse_q[P_RXPOP];
  assign int_id_rd    = pulse_q[P_IDRD];
  assign msr_rd       = pulse_q[P_MSRD];
  assign rx_fifo_rst  = pulse_q[P_RXRST];
  assign tx_fifo_rst  = pulse_q[P_TXRST];
  assign tx_data      = txd_q;
  assign irq_enable   = ien_q;
  assign word_len     = fmt_q.wlen;
  assign two_stop     = fmt_q.stop2;
  assign parity_en    = fmt_q.par;
  assign parity_even  = fmt_q.even;
  assign parity_stick = fmt_q.stick;
  assign break_ctl    = fmt_q.brk;
  assign dtr          = mctl_q[0];
  assign rts          = mctl_q[1];
  assign out1         = mctl_q[2];
  assign irq_out_en   = mctl_q[3];
  assign loopback     = mctl_q[4];
  assign divisor      = {div_hi_q, div_lo_q};
  assign baud_run     = div_nonzero(divisor);
  assign fifo_en      = fen_q;
  assign rx_trigger   = trig_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  wdata,
  input logic        divsel,
  input logic        tx_load,
  input logic        rx_pop,
  input logic        rx_fifo_rst,
  input logic        ovr_evt,
  input logic [7:0]  line_stat,
  input logic [15:0] divisor
);
  // R2
  divsel_no_txload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd0 && divsel) |=> !tx_load);

  // R2
  div_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd0 && divsel) |=> $stable(divisor[7:0]));

  // R4
  rx_pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(rd_en && addr == 3'd0 && !divsel));

  // R7
  rx_fifo_rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_rst |-> $past(wr_en && addr == 3'd2 && wdata[1]));

  // R8
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 3'd5 && !ovr_evt) |=> !line_stat[1]);

  // R9
  thr_busy_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !line_stat[5]);
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .wdata       (wdata),
  .divsel      (fmt_q.divsel),
  .tx_load     (tx_load),
  .rx_pop      (rx_pop),
  .rx_fifo_rst (rx_fifo_rst),
  .ovr_evt     (ovr_evt),
  .line_stat   (line_stat),
  .divisor     (divisor)
);

// File: tb/tb_uart_regfile.sv
`timescale 1ns/1ps
module tb_uart_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic tx_load, rx_pop, int_id_rd, msr_rd, tx_taken = 1'b0;
  logic [7:0] tx_data, rx_data = '0, modem_in = '0;
  logic rx_ready = 1'b0, ovr_evt = 1'b0, par_evt = 1'b0, frm_evt = 1'b0;
  logic [3:0] int_code = '0, irq_enable;
  logic [1:0] word_len, rx_trigger;
  logic two_stop, parity_en, parity_even, parity_stick, break_ctl;
  logic dtr, rts, out1, irq_out_en, loopback, baud_run, fifo_en;
  logic rx_fifo_rst, tx_fifo_rst;
  logic [15:0] divisor;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regfile dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_lstat(logic rdy, logic ovr, logic par, logic frm, logic thr);
    logic [7:0] v;
    v = 8'h00;
    v[0] = rdy; v[1] = ovr; v[2] = par; v[3] = frm; v[5] = thr;
    return v;
  endfunction

  function automatic int baud_div(int refclk, int rate);
    return (refclk + 8 * rate - 1) / (16 * rate);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    logic [7:0] m_ien, m_fmt, m_mctl, m_scr;
    int dv;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd5, v); check("R1 lstat", v, 8'h20);
    rd(3'd3, v); check("R1 fmt", v, 8'h00);
    rd(3'd4, v); check("R1 mctl", v, 8'h00);
    check("R1 divisor/run", {divisor, baud_run, fifo_en, irq_enable}, 0);

    // R3 transmit load, R9 thr
    wr(3'd0, 8'h5A);
    check("R3 tx_load", tx_load, 1); check("R3 tx_data", tx_data, 8'h5A);
    @(negedge clk); check("R3 single pulse", tx_load, 0);
    rd(3'd5, v); check("R9 thr cleared", v, 8'h00);
    @(negedge clk); tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;
    rd(3'd5, v); check("R9 thr set", v, 8'h20);
    // R9 load and taken together -> cleared
    @(negedge clk); addr = 3'd0; wdata = 8'h11; wr_en = 1'b1; tx_taken = 1'b1;
    @(negedge clk); wr_en = 1'b0; tx_taken = 1'b0;
    rd(3'd5, v); check("R9 load wins", v, 8'h00);
    @(negedge clk); tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;

    // R4 receive
    rx_data = 8'hC3; rx_ready = 1'b1;
    rd(3'd0, v); check("R4 rx data", v, 8'hC3); check("R4 rx_pop", rx_pop, 1);
    rd(3'd5, v); check("R8 ready bit", v, 8'h21);
    rx_ready = 1'b0;

    // R5 format
    wr(3'd3, 8'h1B);
    check("R5 fields", {break_ctl, parity_stick, parity_even, parity_en, two_stop, word_len},
          {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11});
    wr(3'd3, 8'h64);
    check("R5 fields2", {break_ctl, parity_stick, parity_even, parity_en, two_stop, word_len},
          {1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b00});
    rd(3'd3, v); check("R5 readback", v, 8'h64);

    // R2 / R10 divisor
    wr(3'd1, 8'h05);
    dv = baud_div(1843200, 9600);
    wr(3'd3, 8'h83);
    wr(3'd0, dv[7:0]); check("R2 no tx_load", tx_load, 0);
    wr(3'd1, dv[15:8]);
    check("R10 divisor", divisor, 16'd12); check("R10 run", baud_run, 1);
    check("R2 ien untouched", irq_enable, 4'h5);
    check("R2 tx_data untouched", tx_data, 8'h11);
    rd(3'd0, v); check("R2 read lo", v, 8'd12); check("R2 no rx_pop", rx_pop, 0);
    rd(3'd1, v); check("R2 read hi", v, 8'd0);
    wr(3'd1, 8'hA5); check("R10 divisor hi", divisor, 16'hA50C);
    wr(3'd1, 8'h00); wr(3'd0, 8'h00); check("R10 zero stops", baud_run, 0);
    wr(3'd3, 8'h03);
    rd(3'd1, v); check("R11 ien readback", v, 8'h05);

    // R7 fifo control
    wr(3'd2, 8'h47);
    check("R7 fifo cfg", {fifo_en, rx_trigger}, 3'b101);
    check("R7 reset pulses", {rx_fifo_rst, tx_fifo_rst}, 2'b11);
    @(negedge clk); check("R7 pulses end", {rx_fifo_rst, tx_fifo_rst}, 2'b00);
    int_code = 4'h4;
    rd(3'd2, v); check("R7 id read", v, 8'hC4); check("R7 id pulse", int_id_rd, 1);
    wr(3'd2, 8'h02); check("R7 rx only", {rx_fifo_rst, tx_fifo_rst, fifo_en}, 3'b100);
    rd(3'd2, v); check("R7 id fifo off", v, 8'h04);

    // R8 sticky errors
    @(negedge clk); ovr_evt = 1'b1; frm_evt = 1'b1;
    @(negedge clk); ovr_evt = 1'b0; frm_evt = 1'b0;
    @(negedge clk); addr = 3'd5; rd_en = 1'b1; par_evt = 1'b1;
    #1 check("R8 read old", rdata, exp_lstat(0, 1, 0, 1, 1));
    @(negedge clk); rd_en = 1'b0; par_evt = 1'b0;
    rd(3'd5, v); check("R8 clear, event survives", v, exp_lstat(0, 0, 1, 0, 1));
    rd(3'd5, v); check("R8 cleared", v, 8'h20);

    // R6 modem control
    wr(3'd4, 8'hFF);
    check("R6 pins", {loopback, irq_out_en, out1, rts, dtr}, 5'h1F);
    rd(3'd4, v); check("R6 readback", v, 8'h1F);
    wr(3'd4, 8'hE2);
    check("R6 pins2", {loopback, irq_out_en, out1, rts, dtr}, 5'h02);

    // R12 modem status
    modem_in = 8'hB0;
    rd(3'd6, v); check("R12 msr", v, 8'hB0); check("R12 msr pulse", msr_rd, 1);

    // R11 ien width and scratch
    wr(3'd1, 8'hFF); check("R11 ien out", irq_enable, 4'hF);
    rd(3'd1, v); check("R11 ien read", v, 8'h0F);
    wr(3'd7, 8'h96); check("R11 scratch no pulse", tx_load, 0);
    rd(3'd7, v); check("R11 scratch", v, 8'h96);

    // Random accesses against a bench model
    m_ien = 8'h0F; m_fmt = 8'h03; m_mctl = 8'h02; m_scr = 8'h96;
    for (int i = 0; i < 200; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      int sel;
      sel = $urandom_range(0, 3);
      d = 8'($urandom);
      a = (sel == 0) ? 3'd1 : (sel == 1) ? 3'd3 : (sel == 2) ? 3'd4 : 3'd7;
      if (a == 3'd3) d[7] = 1'b0;
      if ($urandom_range(0, 1) == 1) begin
        wr(a, d);
        case (a)
          3'd1: m_ien = {4'h0, d[3:0]};
          3'd3: m_fmt = d;
          3'd4: m_mctl = {3'b000, d[4:0]};
          default: m_scr = d;
        endcase
      end else begin
        rd(a, v);
        case (a)
          3'd1: check("R11 rand ien", v, m_ien);
          3'd3: check("R5 rand fmt", v, m_fmt);
          3'd4: check("R6 rand mctl", v, m_mctl);
          default: check("R11 rand scr", v, m_scr);
        endcase
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule